// File: doc/BRIEF.md
# BCD Real-Time Calendar

This peripheral keeps wall-clock time and a calendar date as packed BCD fields behind a small register bus. A clock-enable input stands for the slow RTC oscillator: every cycle where it is high counts as one RTC clock. Two cascaded programmable dividers turn those RTC clocks into a one-per-second calendar step, which carries seconds into minutes, hours, day of month, weekday, month and a two-digit year.

Software must first open a two-key write lock and then request an initialisation phase. It waits for the acknowledge flag, which shows that the calendar is frozen, before it loads time, date or divider values. Reads of time and date come from shadow copies that follow the live counters once per RTC clock. A synchronisation flag that software clears and hardware sets again shows when the shadows are fresh after an update.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, time, date and control read 0x00000000 and status reads 0x00000000. The divider register reads its parameter defaults: first-stage divider 127 in bits 22:16 and second-stage divider 255 in bits 14:0 (0x007F00FF).
- R2: The lock opens only when 0xCA and then 0x53 are written in turn to the key register (offset 0x24). Any other value, 0x53 without a preceding 0xCA, or any key write made while the lock is open closes it again. Control (offset 0x18, hour-format flag in bit 6) changes only while the lock is open.
- R3: Writing status (offset 0x0C) with bit 7 set while the lock is open requests init mode. Bit 6 (acknowledge) rises on the first RTC clock after that request. Clearing bit 7 drops both bits at the same clock edge.
- R4: Writes to time (0x00), date (0x04) and dividers (0x10) take effect only while the lock is open and the acknowledge bit is high; otherwise they are ignored.
- R5: Time holds seconds in bits 6:0, minutes in 14:8 and hours in 21:16. Date holds day in 5:0, month in 12:8, weekday in 15:13 and year in 23:16. Unused bits, unmapped offsets and the key register read as zero, and read data is zero whenever the read enable is low.
- R6: Outside init mode the calendar advances exactly on the ((A+1)*(S+1))-th RTC clock after init mode ends, where A is the first-stage and S the second-stage divider. In init mode the calendar does not move.
- R7: Seconds wrap from 59 to 00 with a carry into minutes, minutes from 59 to 00 with a carry into hours, and hours from 23 to 00 with a carry into the date, whatever the hour-format flag holds.
- R8: The day of month wraps to 01 after 30 for April, June, September and November, after 31 for the other months, and after 28 for February, or 29 when the year is divisible by four.
- R9: The weekday steps on each day change and wraps from 7 to 1. Month 12 wraps to 01 and steps the year, and year 99 wraps to 00.
- R10: Writing status with bit 5 clear clears the sync flag. The flag is set again on the second RTC clock outside init mode after the clear. Time and date reads return shadow values taken from the live calendar at each RTC clock.
- R11: Status bit 4 reads 1 exactly when the live year is nonzero.
- R12: Status only ever shows bits 7, 6, 5 and 4; all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rstN | input | 1 | Active-low synchronous reset |
| rtcCkEn | input | 1 | One-cycle pulse per RTC clock |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable, one cycle per write |
| busRe | input | 1 | Read enable |
| busRdata | output | 32 | Read data, combinational from address |

## Verification
The bound checker watches, on every cycle, properties that tie ports and internal state together. The acknowledge bit may appear only under an init request and only after an RTC clock. The lock may open only straight after the second key. The live time stays frozen during init unless a load is strobed. The status layout and the year-nonzero bit always match what is read, and an idle bus reads zero. The calendar carries across month lengths, leap Februaries, the year wrap, the divider tick position, shadow lag and the clear-then-resync timing of the flag. These depend on whole sequences, so only the bench's directed and random load-and-tick scenarios can show them, each compared with a bench calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam logic [7:0] OFF_TIME  = 8'h00;
  localparam logic [7:0] OFF_DATE  = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h0C;
  localparam logic [7:0] OFF_PRESC = 8'h10;
  localparam logic [7:0] OFF_CTRL  = 8'h18;
  localparam logic [7:0] OFF_KEY   = 8'h24;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int PRE_W   = 7;
  localparam int SEC_W   = 15;
  localparam int PRE_LSB = 16;

  localparam int STAT_INIT  = 7;
  localparam int STAT_ACK   = 6;
  localparam int STAT_SYNC  = 5;
  localparam int STAT_YEAR  = 4;
  localparam int CTRL_FMT   = 6;

  typedef struct packed {
    logic [5:0] hour;
    logic [6:0] minute;
    logic [6:0] second;
  } calTime_t;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] month;
    logic [5:0] day;
  } calDate_t;

  typedef struct packed {
    logic        holdCount;
    logic        loadTime;
    logic        loadDate;
    logic        loadPresc;
    logic [31:0] wrData;
  } calStrobe_t;

  function automatic logic [31:0] timeToWord(calTime_t t);
    logic [31:0] w;
    w = '0;
    w[6:0]   = t.second;
    w[14:8]  = t.minute;
    w[21:16] = t.hour;
    return w;
  endfunction

  function automatic calTime_t wordToTime(logic [31:0] w);
    calTime_t t;
    t.second = w[6:0];
    t.minute = w[14:8];
    t.hour   = w[21:16];
    return t;
  endfunction

  function automatic logic [31:0] dateToWord(calDate_t d);
    logic [31:0] w;
    w = '0;
    w[5:0]   = d.day;
    w[12:8]  = d.month;
    w[15:13] = d.wday;
    w[23:16] = d.year;
    return w;
  endfunction

  function automatic calDate_t wordToDate(logic [31:0] w);
    calDate_t d;
    d.day   = w[5:0];
    d.month = w[12:8];
    d.wday  = w[15:13];
    d.year  = w[23:16];
    return d;
  endfunction

  function automatic logic [7:0] bcdStep(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic isLeapBcd(logic [7:0] y);
    logic [6:0] bin;
    bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] monthLength(logic [4:0] m, logic [7:0] y);
    case (m)
      5'h02:                      return isLeapBcd(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int PRE_RST = 127,
  parameter int SEC_RST = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rtcCkEn,
  input  calStrobe_t  strobe,
  output logic [31:0] timeWord,
  output logic [31:0] dateWord,
  output logic [31:0] prescWord,
  output logic        yearNonZero,
  output calTime_t    liveTime
);

  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RST);
  localparam logic [SEC_W-1:0] SEC_INIT = SEC_W'(SEC_RST);

  calDate_t liveDate;
  calTime_t shadowTime, nextTime;
  calDate_t shadowDate, nextDate;
  logic [PRE_W-1:0] preDiv, preCnt;
  logic [SEC_W-1:0] secDiv, secCnt;
  logic preWrap, secTick;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic [5:0] dayMax;
  logic unusedWr;

  assign unusedWr = ^strobe.wrData;

  // Two-stage divider: first stage every RTC clock, second on first-stage wrap
  assign preWrap = rtcCkEn && !strobe.holdCount && (preCnt == preDiv);
  assign secTick = preWrap && (secCnt == secDiv);

  // Calendar next-state with cascaded carries
  always_comb begin
    nextTime = liveTime;
    nextDate = liveDate;
    dayMax   = monthLength(liveDate.month, liveDate.year);
    secWrap  = liveTime.second >= 7'h59;
    minWrap  = secWrap && (liveTime.minute >= 7'h59);
    hourWrap = minWrap && (liveTime.hour >= 6'h23);
    dayWrap  = hourWrap && (liveDate.day >= dayMax);
    monWrap  = dayWrap && (liveDate.month >= 5'h12);

    nextTime.second = secWrap ? 7'h00 : 7'(bcdStep({1'b0, liveTime.second}));
    if (secWrap)
      nextTime.minute = minWrap ? 7'h00 : 7'(bcdStep({1'b0, liveTime.minute}));
    if (minWrap)
      nextTime.hour = hourWrap ? 6'h00 : 6'(bcdStep({2'b0, liveTime.hour}));
    if (hourWrap) begin
      nextDate.day  = dayWrap ? 6'h01 : 6'(bcdStep({2'b0, liveDate.day}));
      nextDate.wday = (liveDate.wday >= 3'd7) ? 3'd1 : liveDate.wday + 3'd1;
    end
    if (dayWrap)
      nextDate.month = monWrap ? 5'h01 : 5'(bcdStep({3'b0, liveDate.month}));
    if (monWrap)
      nextDate.year = (liveDate.year >= 8'h99) ? 8'h00 : bcdStep(liveDate.year);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preDiv     <= PRE_INIT;
      secDiv     <= SEC_INIT;
      preCnt     <= '0;
      secCnt     <= '0;
      liveTime   <= '0;
      liveDate   <= '0;
      shadowTime <= '0;
      shadowDate <= '0;
    end else begin
      if (strobe.loadPresc) begin
        preDiv <= strobe.wrData[PRE_LSB +: PRE_W];
        secDiv <= strobe.wrData[SEC_W-1:0];
      end

      if (strobe.holdCount) begin
        preCnt <= '0;
        secCnt <= '0;
      end else if (rtcCkEn) begin
        preCnt <= preWrap ? '0 : preCnt + 1'b1;
        if (preWrap) secCnt <= secTick ? '0 : secCnt + 1'b1;
      end

      if (strobe.loadTime)  liveTime <= wordToTime(strobe.wrData);
      else if (secTick)     liveTime <= nextTime;

      if (strobe.loadDate)  liveDate <= wordToDate(strobe.wrData);
      else if (secTick)     liveDate <= nextDate;

      if (rtcCkEn) begin
        shadowTime <= liveTime;
        shadowDate <= liveDate;
      end
    end
  end

  always_comb begin
    prescWord = '0;
    prescWord[SEC_W-1:0]         = secDiv;
    prescWord[PRE_LSB +: PRE_W]  = preDiv;
  end

  assign timeWord    = timeToWord(shadowTime);
  assign dateWord    = dateToWord(shadowDate);
  assign yearNonZero = liveDate.year != 8'h00;

endmodule

// File: rtl/rtc_reg_ctrl.sv
module rtc_reg_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int RSF_EDGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcCkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       timeWord,
  input  logic [31:0]       dateWord,
  input  logic [31:0]       prescWord,
  input  logic              yearNonZero,
  output calStrobe_t        strobe,
  output logic [31:0]       busRdata,
  output logic              initAck,
  output logic              keyOpen
);

  localparam int SYNC_W = (RSF_EDGES > 1) ? $clog2(RSF_EDGES) : 1;

  typedef enum logic [1:0] {KEY_SHUT, KEY_HALF, KEY_OPEN} keyState_t;

  keyState_t keyState;
  logic initReq, initF, syncFlag, fmtBit;
  logic [SYNC_W-1:0] syncCnt;
  logic hitTime, hitDate, hitStat, hitPresc, hitCtrl, hitKey;
  logic wrStat;

  always_comb begin
    hitTime  = busAddr == ADDR_W'(OFF_TIME);
    hitDate  = busAddr == ADDR_W'(OFF_DATE);
    hitStat  = busAddr == ADDR_W'(OFF_STAT);
    hitPresc = busAddr == ADDR_W'(OFF_PRESC);
    hitCtrl  = busAddr == ADDR_W'(OFF_CTRL);
    hitKey   = busAddr == ADDR_W'(OFF_KEY);
  end

  assign keyOpen = keyState == KEY_OPEN;
  assign initAck = initF;
  assign wrStat  = busWe && hitStat;

  // Key sequencer
  always_ff @(posedge clk) begin
    if (!rstN) keyState <= KEY_SHUT;
    else if (busWe && hitKey) begin
      if (busWdata[7:0] == KEY_FIRST)
        keyState <= KEY_HALF;
      else if (busWdata[7:0] == KEY_SECOND && keyState == KEY_HALF)
        keyState <= KEY_OPEN;
      else
        keyState <= KEY_SHUT;
    end
  end

  // Init request and acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReq <= 1'b0;
      initF   <= 1'b0;
    end else if (wrStat && keyOpen) begin
      initReq <= busWdata[STAT_INIT];
      if (!busWdata[STAT_INIT])       initF <= 1'b0;
      else if (rtcCkEn && initReq)    initF <= 1'b1;
    end else if (rtcCkEn && initReq) begin
      initF <= 1'b1;
    end
  end

  // Shadow synchronisation flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncFlag <= 1'b0;
      syncCnt  <= '0;
    end else if (wrStat && !busWdata[STAT_SYNC]) begin
      syncFlag <= 1'b0;
      syncCnt  <= '0;
    end else if (rtcCkEn && !initReq && !syncFlag) begin
      if (syncCnt == SYNC_W'(RSF_EDGES - 1)) syncFlag <= 1'b1;
      else                                   syncCnt  <= syncCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fmtBit <= 1'b0;
    else if (busWe && hitCtrl && keyOpen) fmtBit <= busWdata[CTRL_FMT];
  end

  always_comb begin
    strobe.holdCount = initReq;
    strobe.loadTime  = busWe && hitTime  && keyOpen && initF;
    strobe.loadDate  = busWe && hitDate  && keyOpen && initF;
    strobe.loadPresc = busWe && hitPresc && keyOpen && initF;
    strobe.wrData    = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      if (hitTime)  busRdata = timeWord;
      if (hitDate)  busRdata = dateWord;
      if (hitPresc) busRdata = prescWord;
      if (hitStat) begin
        busRdata[STAT_INIT] = initReq;
        busRdata[STAT_ACK]  = initF;
        busRdata[STAT_SYNC] = syncFlag;
        busRdata[STAT_YEAR] = yearNonZero;
      end
      if (hitCtrl)  busRdata[CTRL_FMT] = fmtBit;
    end
  end

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PRE_RST   = 127,
  parameter int SEC_RST   = 255,
  parameter int RSF_EDGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcCkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [31:0]       busRdata
);

  calStrobe_t  strobes;
  logic [31:0] timeWord, dateWord, prescWord;
  logic        yearNonZero, initAck, keyOpen;
  calTime_t    liveTime;

  rtc_reg_ctrl #(.ADDR_W(ADDR_W), .RSF_EDGES(RSF_EDGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rtcCkEn(rtcCkEn),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .timeWord(timeWord), .dateWord(dateWord), .prescWord(prescWord),
    .yearNonZero(yearNonZero), .strobe(strobes), .busRdata(busRdata),
    .initAck(initAck), .keyOpen(keyOpen)
  );

  rtc_cal_datapath #(.PRE_RST(PRE_RST), .SEC_RST(SEC_RST)) u_dp (
    .clk(clk), .rstN(rstN), .rtcCkEn(rtcCkEn), .strobe(strobes),
    .timeWord(timeWord), .dateWord(dateWord), .prescWord(prescWord),
    .yearNonZero(yearNonZero), .liveTime(liveTime)
  );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              rtcCkEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic [31:0]       busRdata,
  input logic              initReq,
  input logic              loadTime,
  input logic              initAck,
  input logic              keyOpen,
  input logic              yearNonZero,
  input calTime_t          liveTime
);

  logic atStat, atTime, atKey;
  assign atStat = busAddr == ADDR_W'(OFF_STAT);
  assign atTime = busAddr == ADDR_W'(OFF_TIME);
  assign atKey  = busAddr == ADDR_W'(OFF_KEY);

  assert_ack_under_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    initAck |-> initReq);

  assert_ack_after_rtc_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initAck) |-> $past(rtcCkEn && initReq));

  assert_open_after_second_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyOpen) |-> $past(busWe && atKey && busWdata[7:0] == 8'h53));

  assert_frozen_in_init_R6: assert property (@(posedge clk) disable iff (!rstN)
    (initReq && !loadTime) |=> $stable(liveTime));

  assert_locked_time_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atTime && !keyOpen && initReq) |=> $stable(liveTime));

  assert_year_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && atStat) |-> (busRdata[4] == yearNonZero));

  assert_status_layout_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && atStat) |-> (busRdata[31:8] == 24'h0 && busRdata[3:0] == 4'h0));

  assert_idle_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == 32'h0);

endmodule

bind bcd_calendar_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rtcCkEn(rtcCkEn), .busAddr(busAddr),
  .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
  .initReq(strobes.holdCount), .loadTime(strobes.loadTime),
  .initAck(initAck), .keyOpen(keyOpen), .yearNonZero(yearNonZero),
  .liveTime(liveTime)
);

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;

  localparam logic [7:0] A_TIME = 8'h00, A_DATE = 8'h04, A_STAT = 8'h0C;
  localparam logic [7:0] A_PRESC = 8'h10, A_CTRL = 8'h18, A_KEY = 8'h24;

  logic clk = 1'b0, rstN = 1'b0, rtcCkEn = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar_rtc dut (
    .clk(clk), .rstN(rstN), .rtcCkEn(rtcCkEn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a[5:0]; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a[5:0]; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0;
  endtask

  task automatic ck(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtcCkEn = 1'b1;
      @(negedge clk); rtcCkEn = 1'b0;
    end
  endtask

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] tw(int h, int m, int s);
    return {8'h0, bcd(h), bcd(m), bcd(s)};
  endfunction

  function automatic logic [31:0] dw(int d, int mo, int wd, int y);
    return {8'h0, bcd(y), 3'(wd), 5'(bcd(mo)), bcd(d)};
  endfunction

  task automatic advance(inout int h, m, s, d, mo, wd, y);
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd == 7) ? 1 : wd + 1; d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
  endtask

  // Load calendar via unlock + init handshake, dividers A=1 S=2, then resync
  task automatic loadCal(logic [31:0] t, logic [31:0] d);
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53);
    wr(A_STAT, 32'h80); ck(1);
    wr(A_PRESC, 32'h0001_0002);
    wr(A_TIME, t); wr(A_DATE, d);
    wr(A_STAT, 32'h0); wr(A_KEY, 32'hFF);
    ck(2);
  endtask

  task automatic tickCase(string req, int h, int m, int s, int d, int mo, int wd, int y);
    logic [31:0] r, t0;
    t0 = tw(h, m, s);
    loadCal(t0, dw(d, mo, wd, y));
    rd(A_TIME, r); check({req, " R10 shadow after load"}, r, t0);
    rd(A_STAT, r); check({req, " R10/R11 status after load"}, r, {26'h0, 1'b1, (y != 0), 4'h0});
    ck(4);
    rd(A_TIME, r); check({req, " R6 no step before tick visible"}, r, t0);
    ck(1);
    advance(h, m, s, d, mo, wd, y);
    rd(A_TIME, r); check({req, " time after tick"}, r, tw(h, m, s));
    rd(A_DATE, r); check({req, " date after tick"}, r, dw(d, mo, wd, y));
    rd(A_STAT, r); check({req, " R11 year flag after tick"}, {31'h0, r[4]}, {31'h0, (y != 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(A_TIME, r);  check("R1 time", r, 32'h0);
    rd(A_DATE, r);  check("R1 date", r, 32'h0);
    rd(A_STAT, r);  check("R1 status", r, 32'h0);
    rd(A_CTRL, r);  check("R1 control", r, 32'h0);
    rd(A_PRESC, r); check("R1 dividers", r, 32'h007F_00FF);
    #1 check("R5 idle read zero", busRdata, 32'h0);
    rd(8'h08, r);   check("R5 unmapped offset", r, 32'h0);
    rd(A_KEY, r);   check("R5 key reads zero", r, 32'h0);

    // R2 key sequencing via control format bit
    wr(A_CTRL, 32'h40); rd(A_CTRL, r); check("R2 locked write ignored", r, 32'h0);
    wr(A_KEY, 32'h53); wr(A_CTRL, 32'h40); rd(A_CTRL, r); check("R2 second key alone", r, 32'h0);
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h12); wr(A_KEY, 32'h53); wr(A_CTRL, 32'h40);
    rd(A_CTRL, r); check("R2 broken sequence", r, 32'h0);
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53); wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, r); check("R2 unlocked write, R5 only bit 6", r, 32'h40);
    wr(A_KEY, 32'hFF); wr(A_CTRL, 32'h0); rd(A_CTRL, r); check("R2 relocked", r, 32'h40);
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53); wr(A_CTRL, 32'h0); rd(A_CTRL, r); check("R2 reopen", r, 32'h0);

    // R3 init handshake (lock still open)
    wr(A_STAT, 32'h80); rd(A_STAT, r); check("R3 request before ack", r, 32'h80);
    ck(1); rd(A_STAT, r); check("R3 ack after RTC clock", r, 32'hC0);
    wr(A_STAT, 32'h0); rd(A_STAT, r); check("R3 clear drops both", r, 32'h0);
    wr(A_KEY, 32'hFF);

    // Directed calendar corners
    tickCase("R9 year wrap R7", 23, 59, 59, 31, 12, 7, 99);
    tickCase("R8 leap Feb 28", 23, 59, 59, 28, 2, 3, 24);
    tickCase("R8 leap Feb 29", 23, 59, 59, 29, 2, 4, 24);
    tickCase("R8 plain Feb 28", 23, 59, 59, 28, 2, 2, 23);
    tickCase("R8 April 30", 23, 59, 59, 30, 4, 5, 21);
    tickCase("R7 hour carry", 9, 59, 59, 15, 6, 1, 5);
    tickCase("R9 month carry", 23, 59, 59, 31, 7, 6, 40);

    // R4/R6 write gating and hold during init
    loadCal(tw(12, 34, 56), dw(15, 6, 3, 25));
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53); wr(A_STAT, 32'h80);
    wr(A_TIME, 32'h0001_0203);
    ck(1);
    wr(A_KEY, 32'hFF);
    wr(A_TIME, 32'h0011_1111); wr(A_PRESC, 32'h5);
    ck(8);
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53); wr(A_STAT, 32'h0);
    wr(A_TIME, 32'h0022_2222);
    ck(2);
    rd(A_TIME, r); check("R4 R6 gated writes and frozen calendar", r, tw(12, 34, 56));
    rd(A_PRESC, r); check("R4 divider write ignored", r, 32'h0001_0002);
    wr(A_KEY, 32'hFF);

    // R10 sync flag clear and re-set timing
    wr(A_STAT, 32'h0); rd(A_STAT, r); check("R10 flag cleared", {31'h0, r[5]}, 32'h0);
    ck(1); rd(A_STAT, r); check("R10 not yet after one clock", {31'h0, r[5]}, 32'h0);
    ck(1); rd(A_STAT, r); check("R10 set after two clocks", {31'h0, r[5]}, 32'h1);

    // Random calendars biased toward carries
    for (int i = 0; i < 30; i++) begin
      int h, m, s, d, mo, wd, y;
      s  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      m  = ($urandom % 3 != 0) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2 != 0) ? 23 : int'($urandom % 24);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = ($urandom % 2 != 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      wd = 1 + int'($urandom % 7);
      tickCase("R7 R8 R9 random", h, m, s, d, mo, wd, y);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule